// File: doc/BRIEF.md
# Dual-Slot Retirement Unit

This block holds the oldest instructions of an in-order machine in a small shift-style queue and decides, every cycle, whether zero, one or two of them leave the queue from the two head positions. Each entry records whether it is valid, whether it has finished, whether it raised an exception, whether it sits behind an unresolved predicted branch, its instruction class, and how many writes it makes to the condition, integer and floating register files. Finish reports arrive by tag and may come in any order. A branch resolution input clears the speculative marks. A flush input discards speculative work.

The head entry leaves when it has finished cleanly. The entry behind it may leave in the same cycle only if a set of limits all hold. It must be finished, free of exceptions and not speculative. It must be an integer or load instruction. For each register file, the two entries together must need no more write ports than the budget allows. The retire strobes, their tags, the pop count and an exception request are registered. Each one reports the decision taken on the queue state before the last clock edge.

Top module: `dual_retire_unit`

## Requirements
- R1: The head entry retires when it is valid and finished and has no exception. Its speculative mark and class do not matter. `ret0_o` and `ret0_tag_o` show the retirement one clock after the finished state was stored.
- R2: The second entry never retires unless the head entry retires in the same cycle.
- R3: The second entry retires only if it is marked finished.
- R4: The second entry does not retire while its speculative mark is set.
- R5: The second entry does not retire while its exception mark is set.
- R6: The second entry retires only when its class is integer (code 0) or load (code 1). Floating (2) and miscellaneous (3) wait for a later cycle.
- R7: For each register file (condition, integer, floating), the writes of the two entries together must not exceed LIMIT (default 2) for the second entry to retire. A sum of exactly LIMIT is allowed.
- R8: A valid, finished head entry with its exception mark set does not retire. Instead, `exc_req_o` is raised one clock later and held while that entry remains at the head.
- R9: `pop_cnt_o` equals the number of retire strobes. The queue moves down by that amount, so entries retire strictly in enqueue order.
- R10: `enq_ready_o` is low while all DEPTH entries are occupied. An enqueue offered at that time is dropped. Occupancy never exceeds DEPTH.
- R11: A flush discards the oldest speculative entry and every entry younger than it. In the flush cycle nothing retires and nothing is enqueued.
- R12: A branch resolution pulse clears the speculative mark of every queued entry, unless a flush occurs in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| enq_valid_i | input | 1 | Enqueue request |
| enq_ready_o | output | 1 | Queue has a free entry |
| enq_tag_i | input | 4 | Tag of the new entry |
| enq_cls_i | input | 2 | Class: 0 integer, 1 load, 2 floating, 3 miscellaneous |
| enq_spec_i | input | 1 | New entry lies behind an unresolved branch |
| enq_cr_i | input | 2 | Condition register writes of the new entry |
| enq_gpr_i | input | 2 | Integer register writes of the new entry |
| enq_fpr_i | input | 2 | Floating register writes of the new entry |
| fin_valid_i | input | 1 | Finish report valid |
| fin_tag_i | input | 4 | Tag of the finishing entry |
| fin_exc_i | input | 1 | Finishing entry raised an exception |
| br_resolve_i | input | 1 | Pending branch resolved as predicted |
| flush_i | input | 1 | Discard speculative entries |
| ret0_o | output | 1 | Head entry retired |
| ret1_o | output | 1 | Second entry retired |
| pop_cnt_o | output | 2 | Number of entries retired |
| ret0_tag_o | output | 4 | Tag of the head retirement |
| ret1_tag_o | output | 4 | Tag of the second retirement |
| exc_req_o | output | 1 | Head entry is holding an exception |

## Verification
The hardest situation to reach from the ports is a pair of head entries that are both finished when the retire decision is taken. With one finish port and in-order retirement, finishing the head first makes it leave alone. The stimulus therefore finishes the second entry first and the head last. Every limit case (class, speculation, exception, each register budget at and above LIMIT) is built from that same ordering. After each case that retires only one entry, the bench confirms on the next cycle that the held-back entry then leaves from the head slot.

// File: rtl/dretire_pkg.sv
package dretire_pkg;
  localparam int TAG_W = 4;
  localparam int WB_W  = 2;

  typedef enum logic [1:0] {
    CLS_INT  = 2'd0,
    CLS_LOAD = 2'd1,
    CLS_FLT  = 2'd2,
    CLS_MISC = 2'd3
  } cls_e;

  typedef struct packed {
    logic              vld;
    logic              fin;
    logic              exc;
    logic              spec;
    cls_e              cls;
    logic [WB_W-1:0]   cr;
    logic [WB_W-1:0]   gpr;
    logic [WB_W-1:0]   fpr;
    logic [TAG_W-1:0]  tag;
  } ent_t;
endpackage

// File: rtl/dretire_queue.sv
module dretire_queue
  import dretire_pkg::*;
#(
  parameter int DEPTH = 8,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             enq_en,
  input  ent_t             enq_ent,
  input  logic             fin_en,
  input  logic [TAG_W-1:0] fin_tag,
  input  logic             fin_exc,
  input  logic             resolve,
  input  logic             flush,
  input  logic [1:0]       pop,
  output ent_t             head0,
  output ent_t             head1,
  output logic [CW-1:0]    occ,
  output logic             full
);
  ent_t          mem_q [DEPTH];
  ent_t          mem_d [DEPTH];
  ent_t          upd   [DEPTH+2];
  logic [CW-1:0] cnt_q, cnt_d, cut, base;
  logic          enq_go;

  always_comb begin
    // status updates applied before any movement
    for (int i = 0; i < DEPTH + 2; i++) upd[i] = '0;
    for (int i = 0; i < DEPTH; i++) begin
      upd[i] = mem_q[i];
      if (fin_en && mem_q[i].vld && mem_q[i].tag == fin_tag) begin
        upd[i].fin = 1'b1;
        upd[i].exc = mem_q[i].exc | fin_exc;
      end
      if (resolve && !flush) upd[i].spec = 1'b0;
    end

    // first speculative position bounds what survives a flush
    cut = cnt_q;
    for (int i = DEPTH - 1; i >= 0; i--) begin
      if (CW'(i) < cnt_q && mem_q[i].spec) cut = CW'(i);
    end

    base   = cnt_q - CW'(pop);
    enq_go = enq_en && !full && !flush;

    for (int i = 0; i < DEPTH; i++) begin
      if (flush) mem_d[i] = (CW'(i) < cut) ? upd[i] : '0;
      else       mem_d[i] = upd[i + int'(pop)];
      if (enq_go && CW'(i) == base) begin
        mem_d[i]     = enq_ent;
        mem_d[i].vld = 1'b1;
      end
    end

    cnt_d = flush ? cut : base + CW'(enq_go);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
      for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
    end else begin
      cnt_q <= cnt_d;
      for (int i = 0; i < DEPTH; i++) mem_q[i] <= mem_d[i];
    end
  end

  assign head0 = mem_q[0];
  assign head1 = mem_q[1];
  assign occ   = cnt_q;
  assign full  = (cnt_q == CW'(DEPTH));
endmodule

// File: rtl/dretire_budget.sv
module dretire_budget #(
  parameter int W     = 2,
  parameter int LIMIT = 2,
  localparam int SW = W + 1
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  output logic         ok
);
  logic [SW-1:0] sum;
  assign sum = {1'b0, a} + {1'b0, b};
  assign ok  = (sum <= SW'(LIMIT));
endmodule

// File: rtl/dretire_select.sv
module dretire_select
  import dretire_pkg::*;
#(
  parameter int LIMIT = 2,
  localparam int NRF = 3
) (
  input  ent_t h0,
  input  ent_t h1,
  input  logic flush,
  output logic go0,
  output logic go1,
  output logic exc_hit
);
  logic [WB_W-1:0] a_cnt [NRF];
  logic [WB_W-1:0] b_cnt [NRF];
  logic [NRF-1:0]  bud_ok;
  logic            cls_ok;
  logic            unused_bits;

  assign a_cnt[0] = h0.cr;
  assign a_cnt[1] = h0.gpr;
  assign a_cnt[2] = h0.fpr;
  assign b_cnt[0] = h1.cr;
  assign b_cnt[1] = h1.gpr;
  assign b_cnt[2] = h1.fpr;

  generate
    for (genvar k = 0; k < NRF; k++) begin : g_rf
      dretire_budget #(.W(WB_W), .LIMIT(LIMIT)) u_budget (
        .a  (a_cnt[k]),
        .b  (b_cnt[k]),
        .ok (bud_ok[k])
      );
    end
  endgenerate

  assign cls_ok  = (h1.cls == CLS_INT) || (h1.cls == CLS_LOAD);
  assign go0     = !flush && h0.vld && h0.fin && !h0.exc;
  assign exc_hit = !flush && h0.vld && h0.fin && h0.exc;
  assign go1     = go0 && h1.vld && h1.fin && !h1.exc && !h1.spec
                   && cls_ok && (&bud_ok);

  assign unused_bits = ^{h0.spec, h0.cls, h0.tag, h1.tag};
endmodule

// File: rtl/dual_retire_unit.sv
module dual_retire_unit
  import dretire_pkg::*;
#(
  parameter int DEPTH = 8,
  parameter int LIMIT = 2,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             enq_valid_i,
  output logic             enq_ready_o,
  input  logic [TAG_W-1:0] enq_tag_i,
  input  logic [1:0]       enq_cls_i,
  input  logic             enq_spec_i,
  input  logic [WB_W-1:0]  enq_cr_i,
  input  logic [WB_W-1:0]  enq_gpr_i,
  input  logic [WB_W-1:0]  enq_fpr_i,
  input  logic             fin_valid_i,
  input  logic [TAG_W-1:0] fin_tag_i,
  input  logic             fin_exc_i,
  input  logic             br_resolve_i,
  input  logic             flush_i,
  output logic             ret0_o,
  output logic             ret1_o,
  output logic [1:0]       pop_cnt_o,
  output logic [TAG_W-1:0] ret0_tag_o,
  output logic [TAG_W-1:0] ret1_tag_o,
  output logic             exc_req_o
);
  ent_t          enq_ent, head0, head1;
  logic [CW-1:0] occ;
  logic          full, go0, go1, exc_hit;
  logic [1:0]    pop;

  always_comb begin
    enq_ent      = '0;
    enq_ent.vld  = 1'b1;
    enq_ent.spec = enq_spec_i;
    enq_ent.cls  = cls_e'(enq_cls_i);
    enq_ent.cr   = enq_cr_i;
    enq_ent.gpr  = enq_gpr_i;
    enq_ent.fpr  = enq_fpr_i;
    enq_ent.tag  = enq_tag_i;
  end

  assign pop = {1'b0, go0} + {1'b0, go1};

  dretire_queue #(.DEPTH(DEPTH)) u_queue (
    .clk     (clk),
    .rst     (rst),
    .enq_en  (enq_valid_i),
    .enq_ent (enq_ent),
    .fin_en  (fin_valid_i),
    .fin_tag (fin_tag_i),
    .fin_exc (fin_exc_i),
    .resolve (br_resolve_i),
    .flush   (flush_i),
    .pop     (pop),
    .head0   (head0),
    .head1   (head1),
    .occ     (occ),
    .full    (full)
  );

  dretire_select #(.LIMIT(LIMIT)) u_select (
    .h0      (head0),
    .h1      (head1),
    .flush   (flush_i),
    .go0     (go0),
    .go1     (go1),
    .exc_hit (exc_hit)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      ret0_o     <= 1'b0;
      ret1_o     <= 1'b0;
      pop_cnt_o  <= '0;
      ret0_tag_o <= '0;
      ret1_tag_o <= '0;
      exc_req_o  <= 1'b0;
    end else begin
      ret0_o     <= go0;
      ret1_o     <= go1;
      pop_cnt_o  <= pop;
      ret0_tag_o <= head0.tag;
      ret1_tag_o <= head1.tag;
      exc_req_o  <= exc_hit;
    end
  end

  assign enq_ready_o = !full;
endmodule

// File: rtl/dretire_chk.sv
module dretire_chk
  import dretire_pkg::*;
#(
  parameter int DEPTH = 8,
  parameter int LIMIT = 2,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input logic            clk,
  input logic            rst,
  input logic            flush_i,
  input logic            ret0_o,
  input logic            ret1_o,
  input logic [1:0]      pop_cnt_o,
  input logic            exc_req_o,
  input logic [CW-1:0]   occ,
  input logic [WB_W-1:0] s0_cr,
  input logic [WB_W-1:0] s0_gpr,
  input logic [WB_W-1:0] s0_fpr,
  input logic [WB_W-1:0] s1_cr,
  input logic [WB_W-1:0] s1_gpr,
  input logic [WB_W-1:0] s1_fpr,
  input cls_e            s1_cls,
  input logic            s1_fin,
  input logic            s1_exc,
  input logic            s1_spec
);
  AST_PAIR_NEEDS_HEAD: assert property (@(posedge clk) disable iff (rst) ret1_o |-> ret0_o); // R2
  AST_SECOND_FINISHED: assert property (@(posedge clk) disable iff (rst) ret1_o |-> $past(s1_fin)); // R3
  AST_SECOND_NOT_SPEC: assert property (@(posedge clk) disable iff (rst) ret1_o |-> !$past(s1_spec)); // R4
  AST_SECOND_NO_EXC: assert property (@(posedge clk) disable iff (rst) ret1_o |-> !$past(s1_exc)); // R5
  AST_SECOND_CLASS: assert property (@(posedge clk) disable iff (rst)
    ret1_o |-> ($past(s1_cls) == CLS_INT || $past(s1_cls) == CLS_LOAD)); // R6
  AST_CR_BUDGET: assert property (@(posedge clk) disable iff (rst)
    ret1_o |-> (int'($past(s0_cr)) + int'($past(s1_cr)) <= LIMIT)); // R7
  AST_GPR_BUDGET: assert property (@(posedge clk) disable iff (rst)
    ret1_o |-> (int'($past(s0_gpr)) + int'($past(s1_gpr)) <= LIMIT)); // R7
  AST_FPR_BUDGET: assert property (@(posedge clk) disable iff (rst)
    ret1_o |-> (int'($past(s0_fpr)) + int'($past(s1_fpr)) <= LIMIT)); // R7
  AST_EXC_NO_RETIRE: assert property (@(posedge clk) disable iff (rst) exc_req_o |-> !ret0_o); // R8
  AST_POP_MATCHES: assert property (@(posedge clk) disable iff (rst)
    int'(pop_cnt_o) == int'(ret0_o) + int'(ret1_o)); // R9
  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst) int'(occ) <= DEPTH); // R10
  AST_FLUSH_QUIET: assert property (@(posedge clk) disable iff (rst) flush_i |=> !ret0_o); // R11
endmodule

bind dual_retire_unit dretire_chk #(.DEPTH(DEPTH), .LIMIT(LIMIT)) i_chk (
  .clk       (clk),
  .rst       (rst),
  .flush_i   (flush_i),
  .ret0_o    (ret0_o),
  .ret1_o    (ret1_o),
  .pop_cnt_o (pop_cnt_o),
  .exc_req_o (exc_req_o),
  .occ       (occ),
  .s0_cr     (head0.cr),
  .s0_gpr    (head0.gpr),
  .s0_fpr    (head0.fpr),
  .s1_cr     (head1.cr),
  .s1_gpr    (head1.gpr),
  .s1_fpr    (head1.fpr),
  .s1_cls    (head1.cls),
  .s1_fin    (head1.fin),
  .s1_exc    (head1.exc),
  .s1_spec   (head1.spec)
);

// File: tb/test_dual_retire_unit.sv
`timescale 1ns/1ps
module test_dual_retire_unit;
  import dretire_pkg::*;

  logic            clk = 1'b0;
  logic            rst = 1'b1;
  logic            enq_valid_i = 1'b0;
  logic            enq_ready_o;
  logic [3:0]      enq_tag_i = '0;
  logic [1:0]      enq_cls_i = '0;
  logic            enq_spec_i = 1'b0;
  logic [1:0]      enq_cr_i = '0, enq_gpr_i = '0, enq_fpr_i = '0;
  logic            fin_valid_i = 1'b0;
  logic [3:0]      fin_tag_i = '0;
  logic            fin_exc_i = 1'b0;
  logic            br_resolve_i = 1'b0;
  logic            flush_i = 1'b0;
  logic            ret0_o, ret1_o, exc_req_o;
  logic [1:0]      pop_cnt_o;
  logic [3:0]      ret0_tag_o, ret1_tag_o;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  always #2.5 clk = ~clk;

  dual_retire_unit i_dual_retire_unit (
    .clk(clk), .rst(rst),
    .enq_valid_i(enq_valid_i), .enq_ready_o(enq_ready_o), .enq_tag_i(enq_tag_i),
    .enq_cls_i(enq_cls_i), .enq_spec_i(enq_spec_i), .enq_cr_i(enq_cr_i),
    .enq_gpr_i(enq_gpr_i), .enq_fpr_i(enq_fpr_i),
    .fin_valid_i(fin_valid_i), .fin_tag_i(fin_tag_i), .fin_exc_i(fin_exc_i),
    .br_resolve_i(br_resolve_i), .flush_i(flush_i),
    .ret0_o(ret0_o), .ret1_o(ret1_o), .pop_cnt_o(pop_cnt_o),
    .ret0_tag_o(ret0_tag_o), .ret1_tag_o(ret1_tag_o), .exc_req_o(exc_req_o)
  );

  task automatic check(string req, string what, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic do_reset();
    rst = 1'b1;
    enq_valid_i = 0; fin_valid_i = 0; br_resolve_i = 0; flush_i = 0;
    tick(); tick();
    rst = 1'b0;
  endtask

  task automatic enq(int tag, cls_e c, bit sp, int cr, int gpr, int fpr);
    enq_valid_i = 1'b1; enq_tag_i = 4'(tag); enq_cls_i = c; enq_spec_i = sp;
    enq_cr_i = 2'(cr); enq_gpr_i = 2'(gpr); enq_fpr_i = 2'(fpr);
    tick();
    enq_valid_i = 1'b0;
  endtask

  task automatic fin(int tag, bit ex);
    fin_valid_i = 1'b1; fin_tag_i = 4'(tag); fin_exc_i = ex;
    tick();
    fin_valid_i = 1'b0; fin_exc_i = 1'b0;
  endtask

  task automatic expect_ret(string req, bit r0, bit r1, int t0, int t1);
    check(req, "ret0", int'(ret0_o), int'(r0));
    check(req, "ret1", int'(ret1_o), int'(r1));
    check(req, "pop",  int'(pop_cnt_o), int'(r0) + int'(r1));
    if (r0) check(req, "tag0", int'(ret0_tag_o), t0);
    if (r1) check(req, "tag1", int'(ret1_tag_o), t1);
  endtask

  // Head entry A (tag 1) and second entry B (tag 2); B finishes first.
  task automatic pair_case(string req, int a_cr, int a_gpr, int a_fpr,
                           cls_e b_cls, bit b_spec, int b_cr, int b_gpr, int b_fpr,
                           bit dual);
    do_reset();
    enq(1, CLS_INT, 1'b0, a_cr, a_gpr, a_fpr);
    enq(2, b_cls, b_spec, b_cr, b_gpr, b_fpr);
    fin(2, 1'b0);
    fin(1, 1'b0);
    tick();
    if (dual) expect_ret(req, 1, 1, 1, 2);
    else begin
      expect_ret(req, 1, 0, 1, 0);
      tick();
      expect_ret({req, "_late"}, 1, 0, 2, 0);
    end
    tick();
    expect_ret({req, "_empty"}, 0, 0, 0, 0);
  endtask

  task automatic t_reset();
    do_reset();
    check("R10", "ready after reset", int'(enq_ready_o), 1);
    check("R1", "ret0 after reset", int'(ret0_o), 0);
    check("R9", "pop after reset", int'(pop_cnt_o), 0);
    check("R8", "exc after reset", int'(exc_req_o), 0);
  endtask

  task automatic t_basic();
    do_reset();
    enq(1, CLS_INT, 0, 0, 1, 0);
    enq(2, CLS_LOAD, 0, 0, 1, 0);
    fin(1, 0);
    expect_ret("R1", 0, 0, 0, 0);     // decision taken before finish stored
    tick();
    expect_ret("R3", 1, 0, 1, 0);     // second unfinished stays
    fin(2, 0);
    expect_ret("R1", 0, 0, 0, 0);
    tick();
    expect_ret("R1", 1, 0, 2, 0);
    enq(3, CLS_INT, 0, 0, 0, 0);
    enq(4, CLS_LOAD, 0, 0, 0, 0);
    fin(4, 0);
    expect_ret("R2", 0, 0, 0, 0);     // second finished, head not: nothing leaves
    fin(3, 0);
    tick();
    expect_ret("R9", 1, 1, 3, 4);
    tick();
    expect_ret("R9", 0, 0, 0, 0);
  endtask

  task automatic t_exc();
    do_reset();
    enq(5, CLS_INT, 0, 0, 0, 0);
    enq(6, CLS_INT, 0, 0, 0, 0);
    fin(6, 1'b1);
    fin(5, 1'b0);
    tick();
    expect_ret("R5", 1, 0, 5, 0);
    check("R5", "exc early", int'(exc_req_o), 0);
    tick();
    check("R8", "exc_req", int'(exc_req_o), 1);
    expect_ret("R8", 0, 0, 0, 0);
    tick();
    check("R8", "exc_req held", int'(exc_req_o), 1);
  endtask

  task automatic t_spec_resolve();
    pair_case("R4", 0, 0, 0, CLS_INT, 1'b1, 0, 0, 0, 1'b0);
    do_reset();
    enq(3, CLS_INT, 0, 0, 0, 0);
    enq(4, CLS_INT, 1, 0, 0, 0);
    br_resolve_i = 1'b1; tick(); br_resolve_i = 1'b0;
    fin(4, 0);
    fin(3, 0);
    tick();
    expect_ret("R12", 1, 1, 3, 4);
  endtask

  task automatic t_class();
    pair_case("R6", 0, 0, 0, CLS_FLT,  1'b0, 0, 0, 0, 1'b0);
    pair_case("R6", 0, 0, 0, CLS_MISC, 1'b0, 0, 0, 0, 1'b0);
    pair_case("R6", 0, 0, 0, CLS_LOAD, 1'b0, 0, 0, 0, 1'b1);
  endtask

  task automatic t_budget();
    pair_case("R7", 2, 0, 0, CLS_INT,  1'b0, 1, 0, 0, 1'b0);  // cr 3
    pair_case("R7", 2, 0, 0, CLS_INT,  1'b0, 0, 0, 0, 1'b1);  // cr 2
    pair_case("R7", 0, 1, 0, CLS_INT,  1'b0, 0, 1, 0, 1'b1);  // gpr 2
    pair_case("R7", 0, 2, 0, CLS_LOAD, 1'b0, 0, 1, 0, 1'b0);  // gpr 3
    pair_case("R7", 0, 0, 1, CLS_LOAD, 1'b0, 0, 0, 2, 1'b0);  // fpr 3
    pair_case("R7", 0, 0, 1, CLS_LOAD, 1'b0, 0, 0, 1, 1'b1);  // fpr 2
  endtask

  task automatic t_full();
    do_reset();
    for (int t = 0; t < 8; t++) enq(t, CLS_INT, 0, 0, 0, 0);
    check("R10", "ready when full", int'(enq_ready_o), 0);
    enq(9, CLS_INT, 0, 0, 0, 0);       // dropped
    for (int t = 7; t >= 1; t--) fin(t, 0);
    fin(0, 0);
    check("R9", "no early retire", int'(ret0_o), 0);
    for (int p = 0; p < 4; p++) begin
      tick();
      expect_ret("R9", 1, 1, 2 * p, 2 * p + 1);
    end
    check("R10", "ready after drain", int'(enq_ready_o), 1);
    tick();
    expect_ret("R10", 0, 0, 0, 0);     // no trace of tag 9
  endtask

  task automatic t_flush();
    do_reset();
    enq(1, CLS_INT, 0, 0, 0, 0);
    enq(2, CLS_INT, 1, 0, 0, 0);
    enq(3, CLS_INT, 0, 0, 0, 0);
    fin(1, 0);
    flush_i = 1'b1; enq_valid_i = 1'b1; enq_tag_i = 4'd7; tick();
    flush_i = 1'b0; enq_valid_i = 1'b0;
    expect_ret("R11", 0, 0, 0, 0);
    tick();
    expect_ret("R11", 1, 0, 1, 0);
    fin(3, 0);
    fin(2, 0);
    fin(7, 0);
    tick();
    expect_ret("R11", 0, 0, 0, 0);
  endtask

  task automatic summary();
    if (!done) begin
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    t_reset();
    t_basic();
    t_exc();
    t_spec_resolve();
    t_class();
    t_budget();
    t_full();
    t_flush();
    summary();
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog all requirements: actual timeout expected completion");
      summary();
    end
  end
endmodule